// File: doc/BRIEF.md
# Oscillator-Count Voltage Signature Checker

This block measures an on-chip supply or virtual-ground level without an analog converter. A voltage-controlled ring oscillator, whose frequency follows the level under test, clocks a binary counter for a test window whose length is a programmable number of system-clock cycles. The final count is the signature of the die. It rises with the oscillator frequency, and so with the measured voltage.

A single expected value is too strict, because a healthy die may drift and still wake up in time. The checker therefore classifies the signature against an inclusive lower and upper bound. A separate bound pair is supplied for each power-off mode, and the mode under test is chosen when the test starts. The counter saturates instead of wrapping. A saturated count is always reported as a fail.

After each test the signature is loaded into a shift register. Test equipment can read it serially, most significant bit first, in the manner of a scan chain. Start and stop requests reach the oscillator domain through two-flop synchronisers. The count is captured in the system domain only after a request/acknowledge handshake has confirmed that the counter has stopped.

Top module: `osc_sig_checker`

## Requirements
- R1: After reset, `done_o`, `pass_o`, `overflow_o` and `signature_o` are all zero.
- R2: `signature_o` equals the number of rising `osc_i` edges seen while counting. For a window of W cycles at clock period Tc and oscillator period To, the count lies between W*Tc/To and (W+8)*Tc/To+6.
- R3: At a fixed window, a higher oscillator frequency gives a proportionally larger signature. Doubling the frequency at least 1.8 times the count.
- R4: The counter saturates at all-ones (4095 for the default 12-bit width). `overflow_o` is 1 when at least one edge arrived while the count was all-ones.
- R5: When `overflow_o` is 1, `pass_o` is 0 whatever the bounds are.
- R6: Bounds for mode m are `lo_bounds_i[m*CNT_W +: CNT_W]` and `hi_bounds_i[m*CNT_W +: CNT_W]`. Without overflow, `pass_o` is 1 exactly when lo <= signature <= hi, with both ends inclusive.
- R7: `mode_i` and `window_i` are latched by `start_i`. Changing them during a test has no effect on that test.
- R8: `start_i` clears `done_o` and `pass_o`. `done_o` rises when the result is valid. `signature_o`, `pass_o` and `done_o` then hold until the next start.
- R9: The signature is loaded into the scan register when the result is posted. `scan_o` presents bit CNT_W-1 first. Each `clk_i` edge with `scan_en_i` high advances to the next lower bit. Shifting does not change `signature_o`.
- R10: Every test starts counting from zero with the overflow flag cleared, whatever the previous result was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the scan clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_i | input | 1 | Ring-oscillator output to be counted |
| start_i | input | 1 | One-cycle start pulse, accepted when idle |
| mode_i | input | MODE_W | Power-off mode under test |
| window_i | input | WIN_W | Test window length in system cycles |
| lo_bounds_i | input | NUM_MODES*CNT_W | Lower pass bound per mode |
| hi_bounds_i | input | NUM_MODES*CNT_W | Upper pass bound per mode |
| signature_o | output | CNT_W | Captured oscillator count |
| pass_o | output | 1 | Signature inside bounds and no overflow |
| done_o | output | 1 | Result valid |
| overflow_o | output | 1 | Counter saturated during the test |
| scan_en_i | input | 1 | Shift enable for the serial path |
| scan_o | output | 1 | Serial signature, MSB first |

## Verification
Some rules are checked by the embedded properties on every cycle. These are the hold of a saturated count, the freeze of the count outside the counting interval, the stickiness of overflow, overflow forcing fail, pass implying done, and results staying stable until the next start. The scan register is also checked to hold its value and to present the new MSB right after a load. Other behaviour can only be shown by the directed scenarios. This covers the count falling in the band predicted by the frequency and window, the proportional growth with frequency, the inclusive bound edges of each mode, the latching of the mode at start, the serial bit order, and the fresh count after a saturated test.

// File: rtl/osc_sig_pkg.sv
package osc_sig_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WIN,
    ST_DRAIN,
    ST_EVAL
  } seq_state_e;
endpackage

// File: rtl/sig_sync2.sv
module sig_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/sig_osc_counter.sv
module sig_osc_counter #(
  parameter int CNT_W = 12
) (
  input  logic             osc_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             ack_o
);
  logic             run_s, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W:0]   carry;
  logic             ovf_q;
  logic             is_max;

  sig_sync2 #(.W(1)) u_run_sync (
    .clk_i (osc_i),
    .rst_ni(rst_ni),
    .d_i   (run_i),
    .q_o   (run_s)
  );

  // toggle chain: bit i flips when all lower bits are one
  assign carry[0] = 1'b1;
  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    assign carry[i+1]  = carry[i] & cnt_q[i];
    assign cnt_nxt[i]  = cnt_q[i] ^ carry[i];
  end
  assign is_max = carry[CNT_W];

  always_ff @(posedge osc_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_d <= 1'b0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      run_d <= run_s;
      if (run_s && !run_d) begin
        cnt_q <= '0;
        ovf_q <= 1'b0;
      end else if (run_s) begin
        if (is_max) ovf_q <= 1'b1;
        else        cnt_q <= cnt_nxt;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
  assign ack_o = run_d;

  a_r4_sat_hold: assert property (@(posedge osc_i) disable iff (!rst_ni)
    run_s && run_d && (&cnt_q) |=> (&cnt_q));
  a_r4_ovf_sticky: assert property (@(posedge osc_i) disable iff (!rst_ni)
    run_s && run_d && ovf_q |=> ovf_q);
  a_r2_frozen: assert property (@(posedge osc_i) disable iff (!rst_ni)
    !run_s |=> $stable(cnt_q));
endmodule

// File: rtl/sig_window_ctrl.sv
module sig_window_ctrl
  import osc_sig_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int WIN_W     = 16,
  parameter int NUM_MODES = 4,
  localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [WIN_W-1:0]           window_i,
  input  logic [NUM_MODES*CNT_W-1:0] lo_bounds_i,
  input  logic [NUM_MODES*CNT_W-1:0] hi_bounds_i,
  input  logic [CNT_W-1:0]           cnt_i,
  input  logic                       ovf_i,
  input  logic                       ack_i,
  output logic                       req_o,
  output logic                       load_o,
  output logic [CNT_W-1:0]           sig_o,
  output logic                       pass_o,
  output logic                       done_o,
  output logic                       ovf_o
);
  seq_state_e       state_q;
  logic             ack_s;
  logic [MODE_W-1:0] mode_q;
  logic [WIN_W-1:0] win_q, win_cnt_q;
  logic [CNT_W-1:0] sig_q;
  logic             ovf_q, pass_q, done_q, req_q;
  logic [CNT_W-1:0] lo_arr [NUM_MODES];
  logic [CNT_W-1:0] hi_arr [NUM_MODES];
  logic [CNT_W-1:0] lo_sel, hi_sel;
  logic             in_band;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_bnd
    assign lo_arr[m] = lo_bounds_i[m*CNT_W +: CNT_W];
    assign hi_arr[m] = hi_bounds_i[m*CNT_W +: CNT_W];
  end
  assign lo_sel  = lo_arr[mode_q];
  assign hi_sel  = hi_arr[mode_q];
  assign in_band = (sig_q >= lo_sel) && (sig_q <= hi_sel);

  sig_sync2 #(.W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      win_q     <= '0;
      win_cnt_q <= '0;
      sig_q     <= '0;
      ovf_q     <= 1'b0;
      pass_q    <= 1'b0;
      done_q    <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          win_q   <= window_i;
          done_q  <= 1'b0;
          pass_q  <= 1'b0;
          req_q   <= 1'b1;
          state_q <= ST_ARM;
        end
        ST_ARM: if (ack_s) begin
          win_cnt_q <= win_q;
          state_q   <= ST_WIN;
        end
        ST_WIN: begin
          if (win_cnt_q == '0) begin
            req_q   <= 1'b0;
            state_q <= ST_DRAIN;
          end else begin
            win_cnt_q <= win_cnt_q - 1'b1;
          end
        end
        // count is static once the acknowledge has dropped
        ST_DRAIN: if (!ack_s) begin
          sig_q   <= cnt_i;
          ovf_q   <= ovf_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          pass_q  <= !ovf_q && in_band;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = req_q;
  assign load_o = (state_q == ST_EVAL);
  assign sig_o  = sig_q;
  assign pass_o = pass_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;

  a_r5_ovf_fails: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ovf_o |-> !pass_o);
  a_r8_pass_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o);
  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(sig_o) && $stable(pass_o));
  a_r2_no_req_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_o);
endmodule

// File: rtl/sig_scan_shift.sv
module sig_scan_shift #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             shift_i,
  output logic             sdo_o
);
  logic [CNT_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[CNT_W-2:0], 1'b0};
  end

  assign sdo_o = sh_q[CNT_W-1];

  a_r9_load_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> sdo_o == $past(data_i[CNT_W-1]));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(sdo_o));
endmodule

// File: rtl/osc_sig_checker.sv
module osc_sig_checker #(
  parameter int CNT_W     = 12,
  parameter int WIN_W     = 16,
  parameter int NUM_MODES = 4,
  localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       osc_i,
  input  logic                       start_i,
  input  logic [MODE_W-1:0]          mode_i,
  input  logic [WIN_W-1:0]           window_i,
  input  logic [NUM_MODES*CNT_W-1:0] lo_bounds_i,
  input  logic [NUM_MODES*CNT_W-1:0] hi_bounds_i,
  output logic [CNT_W-1:0]           signature_o,
  output logic                       pass_o,
  output logic                       done_o,
  output logic                       overflow_o,
  input  logic                       scan_en_i,
  output logic                       scan_o
);
  logic             run_req, run_ack, load;
  logic [CNT_W-1:0] osc_cnt;
  logic             osc_ovf;

  sig_osc_counter #(.CNT_W(CNT_W)) u_cnt (
    .osc_i (osc_i),
    .rst_ni(rst_ni),
    .run_i (run_req),
    .cnt_o (osc_cnt),
    .ovf_o (osc_ovf),
    .ack_o (run_ack)
  );

  sig_window_ctrl #(
    .CNT_W    (CNT_W),
    .WIN_W    (WIN_W),
    .NUM_MODES(NUM_MODES)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .window_i   (window_i),
    .lo_bounds_i(lo_bounds_i),
    .hi_bounds_i(hi_bounds_i),
    .cnt_i      (osc_cnt),
    .ovf_i      (osc_ovf),
    .ack_i      (run_ack),
    .req_o      (run_req),
    .load_o     (load),
    .sig_o      (signature_o),
    .pass_o     (pass_o),
    .done_o     (done_o),
    .ovf_o      (overflow_o)
  );

  sig_scan_shift #(.CNT_W(CNT_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (signature_o),
    .shift_i(scan_en_i),
    .sdo_o  (scan_o)
  );

  a_r9_msb_on_post: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> scan_o == signature_o[CNT_W-1]);
endmodule

// File: tb/osc_sig_checker_bench.sv
`timescale 1ns/1ps
module osc_sig_checker_bench;
  localparam int  CLK_PERIOD = 10;
  localparam int  CNT_W = 12;
  localparam int  WIN_W = 16;
  localparam int  NM    = 4;
  localparam int  MW    = 2;
  localparam int  MAXC  = (1 << CNT_W) - 1;

  logic clk = 0, osc = 0, rst_n = 0;
  logic start = 0, scan_en = 0;
  logic [MW-1:0] mode = '0;
  logic [WIN_W-1:0] window = '0;
  logic [NM*CNT_W-1:0] lo_b = '0, hi_b = '0;
  logic [CNT_W-1:0] sig;
  logic pass, done, ovf, sdo;
  realtime osc_half = 2.5;
  int osc_ps = 5000;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(osc_half) osc = ~osc;

  osc_sig_checker #(.CNT_W(CNT_W), .WIN_W(WIN_W), .NUM_MODES(NM)) u_osc_sig_checker (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .start_i(start), .mode_i(mode),
    .window_i(window), .lo_bounds_i(lo_b), .hi_bounds_i(hi_b),
    .signature_o(sig), .pass_o(pass), .done_o(done), .overflow_o(ovf),
    .scan_en_i(scan_en), .scan_o(sdo));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_bounds(input int m, input int lo, input int hi);
    lo_b[m*CNT_W +: CNT_W] = CNT_W'(lo);
    hi_b[m*CNT_W +: CNT_W] = CNT_W'(hi);
  endtask

  task automatic run_test(input int w, input int m, input int m_late);
    @(negedge clk);
    mode = MW'(m); window = WIN_W'(w); start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    mode = MW'(m_late); window = WIN_W'(w / 2);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int band_lo(input int w);
    return (w * CLK_PERIOD * 1000) / osc_ps;
  endfunction
  function automatic int band_hi(input int w);
    return ((w + 8) * CLK_PERIOD * 1000) / osc_ps + 6;
  endfunction

  task automatic t_reset();
    check(done == 0 && pass == 0 && ovf == 0, "R1 flags", {done, pass, ovf}, 0);
    check(sig == 0, "R1 signature", int'(sig), 0);
  endtask

  task automatic t_bounds();
    int s;
    set_bounds(0, 100, 400);
    run_test(100, 0, 0);
    s = int'(sig);
    check(s >= band_lo(100) && s <= band_hi(100), "R2 count band", s, band_lo(100));
    check(pass == 1, "R6 wide bounds pass", pass, 1);
    set_bounds(2, s, s);
    set_bounds(3, s + 1, s + 50);
    run_test(100, 2, 2);
    check(int'(sig) == s, "R2 repeatable count", int'(sig), s);
    check(pass == 1, "R6 lo==hi==sig inclusive", pass, 1);
    run_test(100, 3, 3);
    check(pass == 0, "R6 sig below lo", pass, 0);
    set_bounds(1, s - 50, s - 1);
    run_test(100, 1, 1);
    check(pass == 0, "R6 sig above hi", pass, 0);
    // R7: mode and window changed after start must not matter
    run_test(100, 2, 3);
    check(pass == 1, "R7 latched mode", pass, 1);
    check(int'(sig) == s, "R7 latched window", int'(sig), s);
  endtask

  task automatic t_hold();
    logic [CNT_W-1:0] s0;
    @(negedge clk);
    mode = 0; window = 60; start = 1;
    @(negedge clk);
    start = 0;
    check(done == 0 && pass == 0, "R8 start clears done/pass", {done, pass}, 0);
    while (!done) @(negedge clk);
    s0 = sig;
    repeat (30) @(negedge clk);
    check(done == 1 && sig == s0, "R8 result held", int'(sig), int'(s0));
  endtask

  task automatic t_scan();
    logic [CNT_W-1:0] got, s0;
    got = '0;
    s0 = sig;
    @(negedge clk);
    scan_en = 1;
    for (int i = 0; i < CNT_W; i++) begin
      #1 got = {got[CNT_W-2:0], sdo};
      @(negedge clk);
    end
    scan_en = 0;
    check(got == s0, "R9 serial MSB first", int'(got), int'(s0));
    check(sig == s0, "R9 signature untouched", int'(sig), int'(s0));
  endtask

  task automatic t_freq();
    int s1, s2;
    set_bounds(0, 0, MAXC);
    osc_half = 2.0; osc_ps = 4000;
    run_test(200, 0, 0);
    s1 = int'(sig);
    check(s1 >= band_lo(200) && s1 <= band_hi(200), "R2 band at 250MHz", s1, band_lo(200));
    osc_half = 1.0; osc_ps = 2000;
    run_test(200, 0, 0);
    s2 = int'(sig);
    check(s2 >= band_lo(200) && s2 <= band_hi(200), "R2 band at 500MHz", s2, band_lo(200));
    check(s2 * 10 >= s1 * 18, "R3 count scales with frequency", s2, s1 * 2);
  endtask

  task automatic t_overflow();
    set_bounds(0, 0, MAXC);
    run_test(1000, 0, 0);
    check(int'(sig) == MAXC, "R4 saturated value", int'(sig), MAXC);
    check(ovf == 1, "R4 overflow flag", ovf, 1);
    check(pass == 0, "R5 overflow forces fail", pass, 0);
    run_test(100, 0, 0);
    check(ovf == 0, "R10 overflow cleared", ovf, 0);
    check(int'(sig) >= band_lo(100) && int'(sig) <= band_hi(100), "R10 fresh count",
          int'(sig), band_lo(100));
    check(pass == 1, "R10 pass after restart", pass, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_bounds();
    t_hold();
    t_scan();
    t_freq();
    t_overflow();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule